// File: doc/BRIEF.md
# Fractional clock synthesizer port controller

This block is the register-side controller of a six-output digital frequency synthesizer. Each output port turns the fast input clock into a train of one-cycle enable pulses. The average rate is the input rate divided by 2·(I + F/36), where I is an 8-bit integer factor and F is an 8-bit numerator counted in 36ths of one integer step.

Software reaches the block through a simple write strobe and a combinational read port. Through it, software programs a port's divider while the port is held in reset, then releases the port and polls a status bit until the port reports lock. A global synthesizer reset keeps every port from locking. A sticky lost-lock register records both ports that could not start and ports that dropped out of lock.

Each port has its own reset bit, its own lock countdown and its own pulse accumulator. The ports are fully independent of one another.

Top module: `fracsyn_ctrl`

## Requirements
- R1: After reset every register reads zero, no port is locked and `tick_o` is all zero.
- R2: Register map (byte offsets), with bit n of a vector belonging to port n:
  - 0x0C: lock status, read-only.
  - 0x10: lost-lock, write-1-to-clear.
  - 0x14: port hold vector, bits [5:0], read/write.
  - 0x18: control. Only bit 1, the global reset, is stored.
  - 0x1C + 4·n: divider of port n, with I in bits [15:8] and F in bits [7:0].
  
  Unmapped offsets and unstored bits read zero, and writes to 0x0C have no effect.
- R3: While a port's hold bit is 1, the port's status bit is 0 from the cycle after the hold is seen, and the port emits no pulses.
- R4: The hold bit is cleared by a write at clock edge E0. If I is nonzero and the global reset is clear, the status bit reads 1 from edge E0+LOCK_CYCLES+1 onwards and reads 0 before it.
- R5: While control bit 1 is set, no status bit rises. A port waiting to lock restarts its full countdown: it locks LOCK_CYCLES edges after the edge that clears control bit 1.
- R6: If the divider's I field is zero when a port leaves hold, the port's lost-lock bit sets one edge after the release. Its status bit then stays 0 until the port is held again.
- R7: If control bit 1 is set while a port is locked, that port's status bit clears and its lost-lock bit sets on the next edge.
- R8: A lost-lock bit clears only when a 1 is written to it. Writing 0 leaves it unchanged, and a new loss in the same cycle wins over the clear.
- R9: Count N from 0 for each cycle a port has spent locked. The port pulses in cycle N exactly when floor(36(N+1)/P) > floor(36N/P), where P = 72·I + 2·F. Pulses occur only while the port is locked.
- R10: The divider value used for pulse generation is the one in the register when the port leaves hold. Later writes read back at once but change the pulse rate only after the next hold and release.
- R11: Holding, releasing or failing one port does not change the status, lost-lock bit or pulses of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| tick_o | output | NUM_PORTS (6) | One-cycle output pulses, one bit per port |

## Verification
The bound checker watches, on every cycle, the rules that relate signals locally in time. These are:
- a pulse only from a locked port;
- loss of status one cycle after a hold or a global-reset assertion, with the lost-lock bit following;
- no status rise while the global reset is seen;
- no lost-lock bit falling without a matching write of 1.

The exact lock latency, the failure on a zero integer factor and the pulse spacing for fractional ratios can only be shown by the bench's scenarios. The same holds for the snapshot of the divider at release and the isolation between ports. The bench's reference model predicts every port's pulse on every cycle, and direct rate windows (1 in 2, 1 in 5) confirm the long-run ratio.

// File: rtl/fracsyn_pkg.sv
package fracsyn_pkg;

    // Fraction denominator: the numerator counts in 36ths of an integer step
    localparam int unsigned FRAC_DEN = 36;
    localparam int unsigned MFI_W    = 8;
    localparam int unsigned MFN_W    = 8;

    // Period in accumulator units: 72*I + 2*F must fit
    localparam int unsigned PER_W =
        ((MFI_W + 7) > (MFN_W + 1) ? (MFI_W + 7) : (MFN_W + 1)) + 1;

    // Register byte offsets (software-visible, order fixed by the map)
    localparam int unsigned OFS_STAT = 32'h0C;
    localparam int unsigned OFS_LOL  = 32'h10;
    localparam int unsigned OFS_HOLD = 32'h14;
    localparam int unsigned OFS_CTRL = 32'h18;
    localparam int unsigned OFS_DIV0 = 32'h1C;
    localparam int unsigned DIV_STEP = 4;

    localparam int unsigned CTRL_GRST_BIT = 1;

    typedef enum logic [2:0] {
        PS_IDLE = 3'd0,
        PS_HOLD = 3'd1,
        PS_WAIT = 3'd2,
        PS_LOCK = 3'd3,
        PS_FAIL = 3'd4
    } port_state_e;

    typedef struct packed {
        logic [MFI_W-1:0] mfi;
        logic [MFN_W-1:0] mfn;
    } div_cfg_t;

endpackage

// File: rtl/fracsyn_regs.sv
module fracsyn_regs
    import fracsyn_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 6,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_PORTS-1:0]  locked,
    input  logic [NUM_PORTS-1:0]  lol_set,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_PORTS-1:0]  hold_o,
    output logic [NUM_PORTS-1:0]  lol_o,
    output logic                  glob_o,
    output div_cfg_t [NUM_PORTS-1:0] div_o
);

    localparam int unsigned CFG_W = $bits(div_cfg_t);

    typedef struct packed {
        logic [NUM_PORTS-1:0]    hold;
        logic [NUM_PORTS-1:0]    lol;
        logic                    glob;
        div_cfg_t [NUM_PORTS-1:0] div;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [ADDR_W-1:0] div_ofs(input int idx);
        return ADDR_W'(OFS_DIV0 + DIV_STEP * idx);
    endfunction

    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:CFG_W];

    // next-state
    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_HOLD)) r_d.hold = wdata[NUM_PORTS-1:0];
            if (addr == ADDR_W'(OFS_CTRL)) r_d.glob = wdata[CTRL_GRST_BIT];
            if (addr == ADDR_W'(OFS_LOL))  r_d.lol  = r_q.lol & ~wdata[NUM_PORTS-1:0];
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (addr == div_ofs(i)) r_d.div[i] = wdata[CFG_W-1:0];
            end
        end
        // a fresh loss wins over a clear in the same cycle
        r_d.lol = r_d.lol | lol_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STAT)) rdata[NUM_PORTS-1:0] = locked;
        if (addr == ADDR_W'(OFS_LOL))  rdata[NUM_PORTS-1:0] = r_q.lol;
        if (addr == ADDR_W'(OFS_HOLD)) rdata[NUM_PORTS-1:0] = r_q.hold;
        if (addr == ADDR_W'(OFS_CTRL)) rdata[CTRL_GRST_BIT] = r_q.glob;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (addr == div_ofs(i)) rdata[CFG_W-1:0] = r_q.div[i];
        end
    end

    assign hold_o = r_q.hold;
    assign lol_o  = r_q.lol;
    assign glob_o = r_q.glob;
    assign div_o  = r_q.div;

endmodule

// File: rtl/fracsyn_lock.sv
module fracsyn_lock
    import fracsyn_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic glob,
    input  logic cfg_bad,
    output logic locked_o,
    output logic release_o,
    output logic start_o,
    output logic lol_set_o
);

    localparam int unsigned CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    typedef struct packed {
        port_state_e      st;
        logic [CNT_W-1:0] cnt;
    } lock_t;

    lock_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        release_o = 1'b0;
        start_o   = 1'b0;
        lol_set_o = 1'b0;
        if (hold) begin
            l_d.st  = PS_HOLD;
            l_d.cnt = '0;
        end else begin
            case (l_q.st)
                PS_HOLD: begin
                    release_o = 1'b1;
                    l_d.cnt   = '0;
                    if (cfg_bad) begin
                        l_d.st    = PS_FAIL;
                        lol_set_o = 1'b1;
                    end else begin
                        l_d.st = PS_WAIT;
                    end
                end
                PS_WAIT: begin
                    if (glob) begin
                        l_d.cnt = '0;
                    end else if (l_q.cnt == CNT_LAST) begin
                        l_d.st  = PS_LOCK;
                        l_d.cnt = '0;
                        start_o = 1'b1;
                    end else begin
                        l_d.cnt = l_q.cnt + CNT_W'(1);
                    end
                end
                PS_LOCK: begin
                    if (glob) begin
                        l_d.st    = PS_WAIT;
                        l_d.cnt   = '0;
                        lol_set_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{st: PS_IDLE, cnt: '0};
        else        l_q <= l_d;
    end

    assign locked_o = (l_q.st == PS_LOCK);

endmodule

// File: rtl/fracsyn_pulse.sv
module fracsyn_pulse
    import fracsyn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture,
    input  logic     start,
    input  logic     run,
    input  div_cfg_t cfg,
    output logic     tick_o
);

    typedef struct packed {
        div_cfg_t         snap;
        logic [PER_W-1:0] acc;
    } pg_t;

    pg_t p_d, p_q;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] sum;

    always_comb begin
        period = PER_W'(p_q.snap.mfi) * PER_W'(2 * FRAC_DEN)
               + PER_W'(p_q.snap.mfn) * PER_W'(2);
        sum    = p_q.acc + PER_W'(FRAC_DEN);
        tick_o = run && (sum >= period);

        p_d = p_q;
        if (capture) p_d.snap = cfg;
        if (start) begin
            p_d.acc = '0;
        end else if (run) begin
            p_d.acc = tick_o ? (sum - period) : sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

endmodule

// File: rtl/fracsyn_ctrl.sv
module fracsyn_ctrl
    import fracsyn_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 6,
    parameter int unsigned LOCK_CYCLES = 64,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_PORTS-1:0] tick_o
);

    logic [NUM_PORTS-1:0]     stat_vec;
    logic [NUM_PORTS-1:0]     lol_set_vec;
    logic [NUM_PORTS-1:0]     hold_vec;
    logic [NUM_PORTS-1:0]     lol_vec;
    logic                     glob_q;
    div_cfg_t [NUM_PORTS-1:0] div_cfg;

    fracsyn_regs #(
        .NUM_PORTS(NUM_PORTS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .locked (stat_vec),
        .lol_set(lol_set_vec),
        .rdata  (rdata),
        .hold_o (hold_vec),
        .lol_o  (lol_vec),
        .glob_o (glob_q),
        .div_o  (div_cfg)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic rel, start;

        fracsyn_lock #(
            .LOCK_CYCLES(LOCK_CYCLES)
        ) u_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (hold_vec[p]),
            .glob     (glob_q),
            .cfg_bad  (div_cfg[p].mfi == '0),
            .locked_o (stat_vec[p]),
            .release_o(rel),
            .start_o  (start),
            .lol_set_o(lol_set_vec[p])
        );

        fracsyn_pulse u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .capture(rel),
            .start  (start),
            .run    (stat_vec[p]),
            .cfg    (div_cfg[p]),
            .tick_o (tick_o[p])
        );
    end

endmodule

// File: rtl/fracsyn_ctrl_chk.sv
module fracsyn_ctrl_chk
    import fracsyn_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 6,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [NUM_PORTS-1:0] tick,
    input logic [NUM_PORTS-1:0] stat,
    input logic [NUM_PORTS-1:0] lol,
    input logic [NUM_PORTS-1:0] hold,
    input logic                 glob
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        assert_tick_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
            tick[i] |-> stat[i]);

        assert_hold_drops_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
            hold[i] |=> !stat[i]);

        assert_glob_blocks_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> !$past(glob));

        assert_glob_breaks_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && glob && !hold[i]) |=> (lol[i] && !stat[i]));

        assert_lol_only_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lol[i]) |-> $past(wr_en && addr == ADDR_W'(OFS_LOL) && wdata[i]));
    end

endmodule

bind fracsyn_ctrl fracsyn_ctrl_chk #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .tick (tick_o),
    .stat (stat_vec),
    .lol  (lol_vec),
    .hold (hold_vec),
    .glob (glob_q)
);

// File: tb/test_fracsyn_ctrl.sv
module test_fracsyn_ctrl;

    localparam int NP = 6;
    localparam int L  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] tick_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    fracsyn_ctrl #(.NUM_PORTS(NP), .LOCK_CYCLES(L), .ADDR_W(8), .DATA_W(32)) i_fracsyn_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    // state codes: 0 idle, 1 held, 2 waiting, 3 locked, 4 failed
    int m_st[NP], m_cnt[NP], m_n[NP];
    int m_mfi[NP], m_mfn[NP], s_mfi[NP], s_mfn[NP];
    bit [NP-1:0] m_hold, m_lol, m_set;
    bit m_glob;

    function automatic bit exp_tick(input int i);
        int per;
        if (m_st[i] != 3) return 1'b0;
        per = 72 * s_mfi[i] + 2 * s_mfn[i];
        return ((36 * (m_n[i] + 1)) / per) > ((36 * m_n[i]) / per);
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 8'h0C) for (int i = 0; i < NP; i++) v[i] = (m_st[i] == 3);
        else if (a == 8'h10) v[NP-1:0] = m_lol;
        else if (a == 8'h14) v[NP-1:0] = m_hold;
        else if (a == 8'h18) v[1] = m_glob;
        else if (a >= 8'h1C && a < 8'h1C + 4 * NP && a[1:0] == 2'b00)
            v = {16'h0, 8'(m_mfi[(a - 8'h1C) / 4]), 8'(m_mfn[(a - 8'h1C) / 4])};
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_st[i] = 0; m_cnt[i] = 0; m_n[i] = 0;
                m_mfi[i] = 0; m_mfn[i] = 0; s_mfi[i] = 0; s_mfn[i] = 0;
            end
            m_hold = '0; m_lol = '0; m_glob = 1'b0;
        end else begin
            m_set = '0;
            for (int i = 0; i < NP; i++) begin
                if (m_hold[i]) begin
                    m_st[i] = 1; m_cnt[i] = 0;
                end else if (m_st[i] == 1) begin
                    s_mfi[i] = m_mfi[i]; s_mfn[i] = m_mfn[i];
                    m_cnt[i] = 0;
                    if (m_mfi[i] == 0) begin m_st[i] = 4; m_set[i] = 1'b1; end
                    else m_st[i] = 2;
                end else if (m_st[i] == 2) begin
                    if (m_glob) m_cnt[i] = 0;
                    else if (m_cnt[i] == L - 1) begin m_st[i] = 3; m_n[i] = 0; end
                    else m_cnt[i]++;
                end else if (m_st[i] == 3) begin
                    if (m_glob) begin m_st[i] = 2; m_cnt[i] = 0; m_set[i] = 1'b1; end
                    else m_n[i]++;
                end
            end
            if (wr_en) begin
                if (addr == 8'h14) m_hold = wdata[NP-1:0];
                if (addr == 8'h18) m_glob = wdata[1];
                if (addr == 8'h10) m_lol = m_lol & ~wdata[NP-1:0];
                if (addr >= 8'h1C && addr < 8'h1C + 4 * NP && addr[1:0] == 2'b00) begin
                    m_mfi[(addr - 8'h1C) / 4] = int'(wdata[15:8]);
                    m_mfn[(addr - 8'h1C) / 4] = int'(wdata[7:0]);
                end
            end
            m_lol = m_lol | m_set;
        end
    end

    // per-cycle comparison of every port's pulse against the model (R9, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NP; i++) begin
                n_chk++;
                if (tick_o[i] !== exp_tick(i)) begin
                    n_err++;
                    $display("FAIL R9 port %0d cycle %0d: actual %0b expected %0b",
                             i, cyc, tick_o[i], exp_tick(i));
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic count_ticks(input int port, input int len, output int n);
        n = 0;
        repeat (len) begin
            @(negedge clk);
            n += int'(tick_o[port]);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_now(8'h0C, 32'h0, "R1 status");
        rd_now(8'h10, 32'h0, "R1 lol");
        rd_now(8'h14, 32'h0, "R1 hold");
        rd_now(8'h18, 32'h0, "R1 ctrl");
        rd_now(8'h1C, 32'h0, "R1 div0");
        chk("R1 ticks", 32'(tick_o), 32'h0);

        // R2: register map
        wr(8'h1C, 32'hABCD_0312);
        rd_now(8'h1C, 32'h0000_0312, "R2 div0 fields");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_now(8'h18, 32'h2, "R2 ctrl bit1 only");
        wr(8'h18, 32'h0);
        wr(8'h14, 32'hFF);
        rd_now(8'h14, 32'h3F, "R2 hold bits");
        wr(8'h0C, 32'hFFFF);
        rd_now(8'h0C, 32'h0, "R2 status write ignored");
        rd_now(8'h34, 32'h0, "R2 unmapped 0x34");
        rd_now(8'h08, 32'h0, "R2 unmapped 0x08");

        // program dividers while held
        wr(8'h1C, 32'h0100);   // port0 P=72
        wr(8'h20, 32'h0212);   // port1 P=180
        wr(8'h24, 32'h0101);   // port2 P=74
        wr(8'h28, 32'h0007);   // port3 I=0
        wr(8'h2C, 32'h0323);   // port4 P=286
        wr(8'h30, 32'hFFFF);   // port5 P=18870
        rd_now(8'h28, 32'h0007, "R2 div3 readback");

        // R4, R6: release all
        wr(8'h14, 32'h0);
        @(negedge clk);
        rd_now(8'h10, 32'h08, "R6 lol after zero-I release");
        repeat (L - 1) @(negedge clk);
        rd_now(8'h0C, 32'h0, "R4 not locked one edge early");
        @(negedge clk);
        rd_now(8'h0C, 32'h37, "R4 locked on time");

        // R9: rate windows
        count_ticks(0, 100, cnt);
        chk("R9 port0 1-in-2", 32'(cnt), 32'd50);
        count_ticks(1, 100, cnt);
        chk("R9 port1 1-in-5", 32'(cnt), 32'd20);
        repeat (200) @(negedge clk);
        rd_now(8'h0C, 32'h37, "R6 failed port stays unlocked");

        // R10: divider write while running
        wr(8'h20, 32'h0100);
        rd_now(8'h20, 32'h0100, "R10 readback new value");
        count_ticks(1, 100, cnt);
        chk("R10 old rate kept", 32'(cnt), 32'd20);

        // R3, R11: hold port1 only
        wr(8'h14, 32'h02);
        @(negedge clk);
        rd_now(8'h0C, 32'h35, "R3 held port drops, R11 others stay");
        count_ticks(1, 50, cnt);
        chk("R3 no ticks while held", 32'(cnt), 32'd0);
        wr(8'h14, 32'h0);
        repeat (L + 2) @(negedge clk);
        rd_now(8'h0C, 32'h37, "R4 port1 relocked");
        count_ticks(1, 100, cnt);
        chk("R10 new rate after release", 32'(cnt), 32'd50);

        // R7, R5: global reset
        wr(8'h18, 32'h2);
        @(negedge clk);
        rd_now(8'h0C, 32'h0, "R7 status cleared");
        rd_now(8'h10, 32'h3F, "R7 lol set on locked ports");
        repeat (150) @(negedge clk);
        rd_now(8'h0C, 32'h0, "R5 no lock under global reset");
        wr(8'h18, 32'h0);
        repeat (L - 1) @(negedge clk);
        rd_now(8'h0C, 32'h0, "R5 countdown restarted");
        @(negedge clk);
        rd_now(8'h0C, 32'h37, "R5 lock after full count");

        // R8: write-1-to-clear
        wr(8'h10, 32'h0);
        rd_now(8'h10, 32'h3F, "R8 zero write keeps");
        wr(8'h10, 32'h08);
        rd_now(8'h10, 32'h37, "R8 clear one bit");
        wr(8'h10, 32'h37);
        rd_now(8'h10, 32'h0, "R8 clear rest");

        // R11: hold port2, others unaffected
        wr(8'h14, 32'h04);
        @(negedge clk);
        rd_now(8'h0C, 32'h33, "R11 only port2 dropped");
        rd_now(8'h10, 32'h0, "R11 no lol from hold");
        repeat (200) @(negedge clk);

        // model sweep
        for (int a = 8'h0C; a <= 8'h34; a += 4) rd_now(8'(a), mread(8'(a)), "R2 model sweep");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule